// File: doc/BRIEF.md
# Brushless Motor Output Chopping and Fault Gating

This block sits between the commutation position logic and the six gate drivers of a three-phase brushless DC motor stage. It takes the latched Hall position code, the effective rotation direction, the fixed-frequency oscillator tick and the comparator and fault inputs. From these it produces three active-low high-side drive commands and three active-high low-side drive commands. A pulse-width latch is set on each oscillator tick and cleared by the duty comparator or by the peak-current comparator, which limits the current in every cycle. A mode input selects whether only the low-side switches are chopped or both sides are chopped.

A brake request overrides commutation. All high-side switches turn off and all low-side switches turn on. In this mode only supply loss, the coast/over-voltage input and the pulse-width latch can block the low side. A soft-start latch is set by undervoltage or over-current and holds every output off outside braking. It releases only in a cycle with no fault present and the external ramp capacitor reported fully drained. Its state is also an output, so it can drive the discharge switch.

Top module: `bldc_chop_gate`

## Requirements
- R1: While reset is asserted, `hs_drv_n` is 3'b111, `ls_drv` is 3'b000 and `ss_hold` is 1.
- R2: With `dir_rev`=0, Hall codes map to {high phase, low phase}, where phase A is bit 0, B is bit 1 and C is bit 2: 3'b101→{A,B}, 3'b100→{A,C}, 3'b110→{B,C}, 3'b010→{B,A}, 3'b011→{C,A}, 3'b001→{C,B}.
- R3: With `dir_rev`=1, the same table applies with the high and low phases swapped.
- R4: Hall codes 3'b000 and 3'b111 turn every output off outside braking.
- R5: With `four_quad`=0, the selected high-side output stays on regardless of the pulse-width latch, and the selected low-side output is on only while the latch is set.
- R6: With `four_quad`=1, both the selected high-side and low-side outputs are on only while the pulse-width latch is set.
- R7: The pulse-width latch sets on `osc_tick` and clears on `pwm_trip` or `peak_trip`. A clear wins over a simultaneous tick. The latch starts cleared after reset.
- R8: With `brake_req`=1, all high-side outputs are off, and all low-side outputs are on while the latch is set. This holds whatever the values of `four_quad`, the Hall code, `dir_hold`, `ocp_trip` and the soft-start latch.
- R9: During braking, `uvlo` or `coast` forces the low-side outputs off at once.
- R10: `uvlo` or `ocp_trip` sets the soft-start latch (`ss_hold`) on the next edge. While the latch is set, outside braking, every output is off.
- R11: The soft-start latch clears only on an edge where `ss_drained`=1 and neither `uvlo` nor `ocp_trip` is present. An `ss_drained` pulse during a fault has no lasting effect.
- R12: Outside braking, `coast` and `dir_hold` turn every output off while they are held. They are not latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_pos | input | 3 | Latched Hall position code |
| dir_rev | input | 1 | Effective direction, 1 = reverse |
| osc_tick | input | 1 | Oscillator tick, sets the pulse-width latch |
| pwm_trip | input | 1 | Duty comparator trip, clears the latch |
| peak_trip | input | 1 | Peak-current comparator trip, clears the latch |
| ocp_trip | input | 1 | Over-current fault |
| uvlo | input | 1 | Supply undervoltage fault |
| coast | input | 1 | Over-voltage / coast command |
| dir_hold | input | 1 | Direction-change inhibit |
| four_quad | input | 1 | 1 = chop both sides, 0 = chop low side only |
| brake_req | input | 1 | Brake mode request |
| ss_drained | input | 1 | Soft-start capacitor fully discharged |
| hs_drv_n | output | 3 | High-side drive commands, active low |
| ls_drv | output | 3 | Low-side drive commands, active high |
| ss_hold | output | 1 | Soft-start latch state |

## Verification
The drive outputs are registered, so a change on the Hall, direction, mode, brake or fault inputs shows on them after one rising edge. `ss_hold` also follows its set or clear condition after one edge. An oscillator tick or comparator trip first moves the pulse-width latch and reaches the outputs one edge later, two edges in all. The driver applies each stimulus on a falling edge and queues the value due after the next rising edge. For latch events it waits an extra cycle before queuing the chopped result. The monitor compares each queued item a quarter period after that rising edge.

// File: rtl/bldc_chop_pkg.sv
package bldc_chop_pkg;
    localparam int NPHASE = 3;
    localparam int HALL_W = 3;

    typedef logic [NPHASE-1:0] phase_t;
    typedef logic [HALL_W-1:0] hall_t;

    typedef struct packed {
        phase_t hi_n;
        phase_t lo;
    } drive_t;
endpackage

// File: rtl/bldc_commutate.sv
module bldc_commutate
    import bldc_chop_pkg::*;
(
    input  hall_t  hall,
    input  logic   rev,
    output phase_t hi_sel,
    output phase_t lo_sel,
    output logic   valid
);
    phase_t fwd_hi;
    phase_t fwd_lo;

    // Forward table; phase A = bit 0, B = bit 1, C = bit 2 (R2)
    always_comb begin
        fwd_hi = '0;
        fwd_lo = '0;
        valid  = 1'b1;
        unique case (hall)
            3'b101:  begin fwd_hi = 3'b001; fwd_lo = 3'b010; end
            3'b100:  begin fwd_hi = 3'b001; fwd_lo = 3'b100; end
            3'b110:  begin fwd_hi = 3'b010; fwd_lo = 3'b100; end
            3'b010:  begin fwd_hi = 3'b010; fwd_lo = 3'b001; end
            3'b011:  begin fwd_hi = 3'b100; fwd_lo = 3'b001; end
            3'b001:  begin fwd_hi = 3'b100; fwd_lo = 3'b010; end
            default: valid = 1'b0;  // R4
        endcase
    end

    // Reverse direction swaps sides (R3)
    assign hi_sel = rev ? fwd_lo : fwd_hi;
    assign lo_sel = rev ? fwd_hi : fwd_lo;
endmodule

// File: rtl/bldc_pwm_latch.sv
module bldc_pwm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_tick,
    input  logic clr_duty,
    input  logic clr_peak,
    output logic on_q
);
    typedef struct packed {
        logic on;
    } pwm_st_t;

    pwm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_tick)
            st_d.on = 1'b1;
        if (clr_duty || clr_peak)
            st_d.on = 1'b0;  // clear dominates (R7)
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign on_q = st_q.on;

    assert_trip_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_duty || clr_peak) |=> !on_q);
    assert_tick_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_tick && !clr_duty && !clr_peak) |=> on_q);
endmodule

// File: rtl/bldc_ss_latch.sv
module bldc_ss_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_fault,
    input  logic oc_fault,
    input  logic drained,
    output logic hold_q
);
    typedef struct packed {
        logic hold;
    } ss_st_t;

    ss_st_t st_d, st_q;
    logic   fault;

    assign fault = uv_fault || oc_fault;

    always_comb begin
        st_d = st_q;
        if (fault)
            st_d.hold = 1'b1;
        else if (drained)
            st_d.hold = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{hold: 1'b1};
        else
            st_q <= st_d;
    end

    assign hold_q = st_q.hold;

    assert_fault_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> hold_q);
    assert_hold_until_drained_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !drained) |=> hold_q);
endmodule

// File: rtl/bldc_chop_gate.sv
module bldc_chop_gate
    import bldc_chop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALL_W-1:0] hall_pos,
    input  logic              dir_rev,
    input  logic              osc_tick,
    input  logic              pwm_trip,
    input  logic              peak_trip,
    input  logic              ocp_trip,
    input  logic              uvlo,
    input  logic              coast,
    input  logic              dir_hold,
    input  logic              four_quad,
    input  logic              brake_req,
    input  logic              ss_drained,
    output logic [NPHASE-1:0] hs_drv_n,
    output logic [NPHASE-1:0] ls_drv,
    output logic              ss_hold
);
    phase_t hi_sel, lo_sel;
    logic   hall_ok;
    logic   pwm_on;
    logic   ss_q;
    logic   run_block;
    phase_t en_hi, en_lo;
    drive_t drv_d, drv_q;

    bldc_commutate u_comm (
        .hall   (hall_pos),
        .rev    (dir_rev),
        .hi_sel (hi_sel),
        .lo_sel (lo_sel),
        .valid  (hall_ok)
    );

    bldc_pwm_latch u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_tick (osc_tick),
        .clr_duty (pwm_trip),
        .clr_peak (peak_trip),
        .on_q     (pwm_on)
    );

    bldc_ss_latch u_ss (
        .clk      (clk),
        .rst_n    (rst_n),
        .uv_fault (uvlo),
        .oc_fault (ocp_trip),
        .drained  (ss_drained),
        .hold_q   (ss_q)
    );

    assign run_block = ss_q || uvlo || ocp_trip || coast || dir_hold || !hall_ok;

    always_comb begin
        en_hi = '0;
        en_lo = '0;
        if (brake_req) begin
            // R8/R9: braking has its own short list of inhibits
            if (pwm_on && !uvlo && !coast)
                en_lo = '1;
        end else if (!run_block) begin
            en_lo = lo_sel & {NPHASE{pwm_on}};
            en_hi = four_quad ? (hi_sel & {NPHASE{pwm_on}}) : hi_sel;  // R6 / R5
        end
        drv_d.hi_n = ~en_hi;
        drv_d.lo   = en_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            drv_q <= '{hi_n: '1, lo: '0};
        else
            drv_q <= drv_d;
    end

    assign hs_drv_n = drv_q.hi_n;
    assign ls_drv   = drv_q.lo;
    assign ss_hold  = ss_q;

    assert_one_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~hs_drv_n));
    assert_no_leg_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~hs_drv_n) & ls_drv) == '0);
    assert_brake_high_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brake_req |=> (hs_drv_n == '1));
    assert_brake_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_req && (uvlo || coast)) |=> (ls_drv == '0));
    assert_ss_forces_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_hold && !brake_req) |=> (hs_drv_n == '1 && ls_drv == '0));
    assert_coast_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((coast || dir_hold) && !brake_req) |=> (hs_drv_n == '1 && ls_drv == '0));
endmodule

// File: tb/bldc_chop_gate_tb.sv
module bldc_chop_gate_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_pos = 3'b101;
    logic       dir_rev = 0, osc_tick = 0, pwm_trip = 0, peak_trip = 0;
    logic       ocp_trip = 0, uvlo = 0, coast = 0, dir_hold = 0;
    logic       four_quad = 0, brake_req = 0, ss_drained = 0;
    logic [2:0] hs_drv_n, ls_drv;
    logic       ss_hold;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] hn;
        logic [2:0] lo;
        logic       ss;
        string      tag;
    } item_t;
    item_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    bldc_chop_gate u_dut (
        .clk(clk), .rst_n(rst_n), .hall_pos(hall_pos), .dir_rev(dir_rev),
        .osc_tick(osc_tick), .pwm_trip(pwm_trip), .peak_trip(peak_trip),
        .ocp_trip(ocp_trip), .uvlo(uvlo), .coast(coast), .dir_hold(dir_hold),
        .four_quad(four_quad), .brake_req(brake_req), .ss_drained(ss_drained),
        .hs_drv_n(hs_drv_n), .ls_drv(ls_drv), .ss_hold(ss_hold)
    );

    task automatic compare(input logic [2:0] hn, input logic [2:0] lo,
                           input logic ss, input string tag);
        checks++;
        if (hs_drv_n !== hn || ls_drv !== lo || ss_hold !== ss) begin
            errors++;
            $display("FAIL %s: got hs_n=%b ls=%b ss=%b expected hs_n=%b ls=%b ss=%b",
                     tag, hs_drv_n, ls_drv, ss_hold, hn, lo, ss);
        end
    endtask

    // Driver side: queue value due after the next rising edge
    task automatic want(input logic [2:0] hn, input logic [2:0] lo,
                        input logic ss, input string tag);
        item_t it;
        it.hn = hn; it.lo = lo; it.ss = ss; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor side
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                compare(it.hn, it.lo, it.ss, it.tag);
            end
        end
    end

    // Independent commutation table: {hi one-hot, lo one-hot}
    function automatic logic [5:0] table_fwd(input logic [2:0] h);
        case (h)
            3'b101: return {3'b001, 3'b010};
            3'b100: return {3'b001, 3'b100};
            3'b110: return {3'b010, 3'b100};
            3'b010: return {3'b010, 3'b001};
            3'b011: return {3'b100, 3'b001};
            3'b001: return {3'b100, 3'b010};
            default: return 6'b0;
        endcase
    endfunction

    initial begin
        #(CLK_P*20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(3'b111, 3'b000, 1'b1, "R1 reset state");
        rst_n = 1'b1;

        // R11: release soft start
        @(negedge clk); ss_drained = 1; want(3'b111, 3'b000, 0, "R11 drained clears");
        @(negedge clk); ss_drained = 0; want(3'b110, 3'b000, 0, "R5 high on latch clear");
        // R7: tick sets latch, visible after two edges
        @(negedge clk); osc_tick = 1;   want(3'b110, 3'b000, 0, "R7 tick pending");
        @(negedge clk); osc_tick = 0;   want(3'b110, 3'b010, 0, "R7 tick sets latch");

        // R2 / R3: full table in both directions
        for (int d = 0; d < 2; d++) begin
            for (int h = 1; h < 7; h++) begin
                logic [5:0] e;
                e = table_fwd(3'(h));
                @(negedge clk);
                dir_rev = d[0]; hall_pos = 3'(h);
                if (d == 0) want(~e[5:3], e[2:0], 0, "R2 forward table");
                else        want(~e[2:0], e[5:3], 0, "R3 reverse swap");
            end
        end
        // R4: invalid codes
        @(negedge clk); dir_rev = 0; hall_pos = 3'b000; want(3'b111, 3'b000, 0, "R4 code 000");
        @(negedge clk); hall_pos = 3'b111; want(3'b111, 3'b000, 0, "R4 code 111");
        @(negedge clk); hall_pos = 3'b101; want(3'b110, 3'b010, 0, "R2 restore");

        // R5: two-quadrant chop via duty trip
        @(negedge clk); pwm_trip = 1; want(3'b110, 3'b010, 0, "R7 trip pending");
        @(negedge clk); pwm_trip = 0; want(3'b110, 3'b000, 0, "R5 low chopped high kept");
        // R6: four-quadrant
        @(negedge clk); four_quad = 1; want(3'b111, 3'b000, 0, "R6 both chopped off");
        @(negedge clk); osc_tick = 1;  want(3'b111, 3'b000, 0, "R6 tick pending");
        @(negedge clk); osc_tick = 0;  want(3'b110, 3'b010, 0, "R6 both on");
        // R7: peak trip
        @(negedge clk); peak_trip = 1; want(3'b110, 3'b010, 0, "R7 peak pending");
        @(negedge clk); peak_trip = 0; want(3'b111, 3'b000, 0, "R7 peak clears");
        // R7: clear beats tick
        @(negedge clk); osc_tick = 1; pwm_trip = 1; want(3'b111, 3'b000, 0, "R7 tick+trip");
        @(negedge clk); osc_tick = 0; pwm_trip = 0; want(3'b111, 3'b000, 0, "R7 clear wins");
        @(negedge clk); osc_tick = 1; want(3'b111, 3'b000, 0, "R7 retick");
        @(negedge clk); osc_tick = 0; want(3'b110, 3'b010, 0, "R7 set again");

        // R12: coast and direction inhibit, not latched
        @(negedge clk); coast = 1;    want(3'b111, 3'b000, 0, "R12 coast off");
        @(negedge clk); coast = 0;    want(3'b110, 3'b010, 0, "R12 coast released");
        @(negedge clk); dir_hold = 1; want(3'b111, 3'b000, 0, "R12 dir hold off");
        @(negedge clk); dir_hold = 0; want(3'b110, 3'b010, 0, "R12 dir hold released");

        // R8 / R9: brake
        @(negedge clk); brake_req = 1; hall_pos = 3'b000; want(3'b111, 3'b111, 0, "R8 brake lows on");
        @(negedge clk); dir_hold = 1; want(3'b111, 3'b111, 0, "R8 dir hold ignored");
        @(negedge clk); dir_hold = 0; four_quad = 0; want(3'b111, 3'b111, 0, "R8 quad ignored");
        @(negedge clk); coast = 1;    want(3'b111, 3'b000, 0, "R9 coast blocks brake");
        @(negedge clk); coast = 0;    want(3'b111, 3'b111, 0, "R9 coast released");
        @(negedge clk); pwm_trip = 1; want(3'b111, 3'b111, 0, "R9 trip pending");
        @(negedge clk); pwm_trip = 0; want(3'b111, 3'b000, 0, "R9 latch blocks brake");
        @(negedge clk); osc_tick = 1; want(3'b111, 3'b000, 0, "R9 tick pending");
        @(negedge clk); osc_tick = 0; want(3'b111, 3'b111, 0, "R8 brake restored");
        @(negedge clk); uvlo = 1;     want(3'b111, 3'b000, 1, "R9 uvlo blocks brake R10 set");
        @(negedge clk); uvlo = 0;     want(3'b111, 3'b111, 1, "R8 brake ignores soft start");

        // R10 / R11: soft-start hold outside braking
        @(negedge clk); brake_req = 0; hall_pos = 3'b101; want(3'b111, 3'b000, 1, "R10 latch holds off");
        @(negedge clk); ocp_trip = 1; ss_drained = 1; want(3'b111, 3'b000, 1, "R11 drained during fault");
        @(negedge clk); ocp_trip = 0; ss_drained = 0; want(3'b111, 3'b000, 1, "R11 still latched");
        @(negedge clk); ss_drained = 1; want(3'b111, 3'b000, 0, "R11 clears");
        @(negedge clk); ss_drained = 0; want(3'b110, 3'b010, 0, "R11 outputs resume");
        @(negedge clk); ocp_trip = 1;   want(3'b111, 3'b000, 1, "R10 overcurrent sets");
        @(negedge clk); ocp_trip = 0;   want(3'b111, 3'b000, 1, "R10 stays latched");

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule